// File: doc/BRIEF.md
# Trace Message Queue With Overrun Reporting

This block sits between a debug unit that produces fixed-width trace messages and the transmitter of the auxiliary output port. Messages can arrive faster than the port drains them, so the queue holds them and releases the most urgent pending message first. Each message carries a 4-bit type, a 32-bit payload and a 2-bit priority level. Messages at the same level leave in arrival order.

The producer cannot be stalled. A message offered while the queue has no room is lost. The queue counts such losses. As soon as a slot is free, it places an error message in the queue that carries the count, so the debugger learns how much trace is missing. An optional watermark mode raises a halt request to the core once occupancy reaches a programmed level. With a suitable level, the core stops before any loss can occur. The request has hysteresis, so it does not toggle on every message.

Top module: `trace_msg_queue`

## Requirements
- R1: After reset, out_valid and halt_req are low and in_ready is high.
- R2: A message accepted on a cycle with in_valid and in_ready both high later appears on out_type, out_prio and out_payload with all fields unchanged.
- R3: The queue holds at most 16 messages. in_ready is low whenever 16 are held, and high with fewer held unless an error message is pending (R6).
- R4: Among held messages, the output presents one with the highest out_prio (3 is most urgent). Messages of equal priority leave in arrival order.
- R5: A message offered while in_ready is low is lost and is added to a loss count.
- R6: While the loss count is nonzero, in_ready is low. In the first cycle with fewer than 16 held, an error message is queued at priority 3 with type 4'hF and the loss count in payload bits [7:0], upper bits zero. This places it ahead of every message that arrives later. The count then restarts at zero, or at one if a message is lost in that same cycle.
- R7: The loss count saturates at 255.
- R8: With wm_en high, halt_req rises on the clock edge after the one at which occupancy first reaches at least wm_level.
- R9: Once high, halt_req stays high until occupancy falls below wm_level minus 2 (floor 0), and falls one edge later. With wm_en low, halt_req is low from the next edge.
- R10: out_valid is high exactly when at least one message is held. A message leaves on a cycle with out_valid and out_ready high. An accept and a removal in the same cycle leave occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer offers a message |
| in_ready | output | 1 | Queue takes the offered message this cycle |
| in_type | input | 4 | Message type |
| in_prio | input | 2 | Message priority, 3 most urgent |
| in_payload | input | 32 | Message payload |
| out_valid | output | 1 | A message is presented |
| out_ready | input | 1 | Transmitter takes the presented message |
| out_type | output | 4 | Presented message type |
| out_prio | output | 2 | Presented message priority |
| out_payload | output | 32 | Presented message payload |
| wm_en | input | 1 | Enable watermark halt mode |
| wm_level | input | 5 | Occupancy that raises the halt request |
| halt_req | output | 1 | Request to halt the core |

## Verification
A wrong occupancy count shows at the ports within one cycle. in_ready drops early or late around the sixteenth message, and halt_req switches at the wrong level on the edge after. A fault in one lane's pointers shows at the next removal from that priority level, as a wrong or repeated payload. A fault in the loss counter shows only when the error message reaches the output. The bench therefore drains the queue past that message and compares its payload to the number of offers it refused.

// File: rtl/tmq_pkg.sv
package tmq_pkg;

  localparam int TYPE_W = 4;
  localparam int PAY_W  = 32;
  localparam int DROP_W = 8;
  localparam int MSG_W  = TYPE_W + PAY_W;

  typedef struct packed {
    logic [TYPE_W-1:0] mtype;
    logic [PAY_W-1:0]  pay;
  } tmq_msg_t;

  // Saturating increment of the loss counter.
  function automatic logic [DROP_W-1:0] drop_inc(input logic [DROP_W-1:0] cur);
    if (cur == {DROP_W{1'b1}}) return cur;
    return cur + 1'b1;
  endfunction

  // Lower hysteresis bound: level minus two, floored at zero.
  function automatic int unsigned wm_low(input int unsigned level);
    return (level > 2) ? level - 2 : 0;
  endfunction

  // Next halt request given current state, enable, occupancy and level.
  function automatic logic halt_next(input logic cur, input logic en,
                                     input int unsigned occ, input int unsigned level);
    if (!en) return 1'b0;
    if (occ >= level) return 1'b1;
    if (occ < wm_low(level)) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/tmq_lane.sv
module tmq_lane #(
  parameter int DEPTH = 16,
  parameter int W     = 36
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic                       nonempty,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] wrap(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wrap(wp);
      if (pop)  rp <= wrap(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  assign rdata    = mem[rp];
  assign nonempty = (cnt != '0);
  assign fill     = cnt;

  p_lane_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (cnt < CW'(DEPTH)));
  p_lane_pop_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty);

endmodule

// File: rtl/tmq_pick.sv
module tmq_pick #(
  parameter int NPRIO = 4
) (
  input  logic [NPRIO-1:0]               held,
  output logic [$clog2(NPRIO)-1:0]       sel,
  output logic                           any
);
  localparam int SW = $clog2(NPRIO);

  always_comb begin
    sel = '0;
    for (int i = 0; i < NPRIO; i++) begin
      if (held[i]) sel = SW'(i);
    end
  end

  assign any = |held;

  always_comb begin
    if (any) p_pick_held_r4: assert (held[sel]);
  end

endmodule

// File: rtl/tmq_ovf.sv
module tmq_ovf
  import tmq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drop,
  input  logic              inject,
  output logic              err_pend,
  output logic [DROP_W-1:0] lost
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lost <= '0;
    end else if (inject) begin
      lost <= drop ? DROP_W'(1) : '0;
    end else if (drop) begin
      lost <= drop_inc(lost);
    end
  end

  assign err_pend = (lost != '0);

  p_loss_noted_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> err_pend);
  p_loss_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !inject && (&lost)) |=> (&lost));
  p_inject_needs_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inject |-> err_pend);

endmodule

// File: rtl/tmq_wm.sv
module tmq_wm
  import tmq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] level,
  input  logic [CW-1:0] occ,
  output logic          halt_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) halt_req <= 1'b0;
    else        halt_req <= halt_next(halt_req, en, int'(occ), int'(level));
  end

  p_halt_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !halt_req);
  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && en && ({1'b0, occ} + 2 >= {1'b0, level})) |=> halt_req);
  p_halt_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && occ >= level) |=> halt_req);

endmodule

// File: rtl/trace_msg_queue.sv
module trace_msg_queue
  import tmq_pkg::*;
#(
  parameter int          DEPTH    = 16,
  parameter int          NPRIO    = 4,
  parameter logic [3:0]  ERR_TYPE = 4'hF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [3:0]  in_type,
  input  logic [1:0]  in_prio,
  input  logic [31:0] in_payload,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [3:0]  out_type,
  output logic [1:0]  out_prio,
  output logic [31:0] out_payload,
  input  logic        wm_en,
  input  logic [4:0]  wm_level,
  output logic        halt_req
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int SW = $clog2(NPRIO);

  logic [CW-1:0]     occ;
  logic              room, accept, drop, inject, pop, push;
  logic              err_pend;
  logic [DROP_W-1:0] lost;
  tmq_msg_t          wmsg;
  logic [NPRIO-1:0]  lane_push, lane_pop, lane_held;
  tmq_msg_t          lane_rd [NPRIO];
  logic [CW-1:0]     lane_fill [NPRIO];
  logic [SW-1:0]     sel;
  logic              any;

  assign room     = (occ < CW'(DEPTH));
  assign in_ready = room && !err_pend;
  assign accept   = in_valid && in_ready;
  assign drop     = in_valid && !in_ready;
  assign inject   = err_pend && room;
  assign push     = accept || inject;
  assign pop      = any && out_ready;

  always_comb begin
    if (inject) begin
      wmsg.mtype = ERR_TYPE;
      wmsg.pay   = PAY_W'(lost);
    end else begin
      wmsg.mtype = in_type;
      wmsg.pay   = in_payload;
    end
  end

  generate
    for (genvar g = 0; g < NPRIO; g++) begin : g_lane
      assign lane_push[g] = (accept && in_prio == SW'(g)) ||
                            (inject && g == NPRIO-1);
      assign lane_pop[g]  = pop && (sel == SW'(g));
      tmq_lane #(.DEPTH(DEPTH), .W(MSG_W)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (lane_push[g]),
        .wdata    (wmsg),
        .pop      (lane_pop[g]),
        .rdata    (lane_rd[g]),
        .nonempty (lane_held[g]),
        .fill     (lane_fill[g])
      );
    end
  endgenerate

  tmq_pick #(.NPRIO(NPRIO)) u_pick (
    .held (lane_held),
    .sel  (sel),
    .any  (any)
  );

  tmq_ovf u_ovf (
    .clk      (clk),
    .rst_n    (rst_n),
    .drop     (drop),
    .inject   (inject),
    .err_pend (err_pend),
    .lost     (lost)
  );

  tmq_wm #(.CW(CW)) u_wm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (wm_en),
    .level    (CW'(wm_level)),
    .occ      (occ),
    .halt_req (halt_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
    end else begin
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign out_valid   = any;
  assign out_type    = lane_rd[sel].mtype;
  assign out_payload = lane_rd[sel].pay;
  assign out_prio    = sel;

  logic [CW+1:0] fill_sum;
  always_comb begin
    fill_sum = '0;
    for (int i = 0; i < NPRIO; i++) fill_sum = fill_sum + (CW+2)'(lane_fill[i]);
  end

  p_occ_matches_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_sum == (CW+2)'(occ));
  p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));
  p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CW'(DEPTH)) |-> !in_ready);
  p_inject_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inject |-> !accept);
  p_valid_iff_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (occ != '0));
  p_swap_keeps_occ_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> occ == $past(occ));

endmodule

// File: tb/trace_msg_queue_bench.sv
module trace_msg_queue_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b0, wm_en = 1'b0;
  logic [3:0]  in_type = '0;
  logic [1:0]  in_prio = '0;
  logic [31:0] in_payload = '0;
  logic [4:0]  wm_level = 5'd16;
  logic        in_ready, out_valid, halt_req;
  logic [3:0]  out_type;
  logic [1:0]  out_prio;
  logic [31:0] out_payload;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trace_msg_queue u_trace_msg_queue (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type),
    .in_prio(in_prio), .in_payload(in_payload),
    .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
    .out_prio(out_prio), .out_payload(out_payload),
    .wm_en(wm_en), .wm_level(wm_level), .halt_req(halt_req)
  );

  // {prio, type, payload}
  localparam logic [37:0] VEC [8] = '{
    {2'd1, 4'h2, 32'h1111_0001},
    {2'd0, 4'h3, 32'h0000_0002},
    {2'd3, 4'h4, 32'h3333_0003},
    {2'd1, 4'h5, 32'h1111_0004},
    {2'd2, 4'h6, 32'h2222_0005},
    {2'd3, 4'h7, 32'h3333_0006},
    {2'd0, 4'h8, 32'h0000_0007},
    {2'd2, 4'h9, 32'h2222_0008}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] p, input logic [3:0] t, input logic [31:0] d,
                      input logic exp_rdy, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_prio = p; in_type = t; in_payload = d;
    chk(req, in_ready, exp_rdy);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_chk(input logic [1:0] p, input logic [3:0] t, input logic [31:0] d,
                         input string req);
    @(negedge clk);
    chk(req, {out_valid, out_prio, out_type, out_payload}, {1'b1, p, t, d});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    out_ready = 1'b1;
    while (out_valid) @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {out_valid, in_ready, halt_req}, 3'b010);

    // R2 R4: vector table, expected order from a priority model
    for (int i = 0; i < 8; i++) push(VEC[i][37:36], VEC[i][35:32], VEC[i][31:0], 1'b1, "R2");
    for (int p = 3; p >= 0; p--)
      for (int i = 0; i < 8; i++)
        if (VEC[i][37:36] == 2'(p)) pop_chk(VEC[i][37:36], VEC[i][35:32], VEC[i][31:0], "R4");
    @(negedge clk);
    chk("R10", out_valid, 1'b0);

    // R3 R5 R6: fill, lose three, error message after one slot frees
    for (int i = 0; i < 16; i++) push(2'd0, 4'h1, 32'(i), 1'b1, "R3");
    chk("R3", in_ready, 1'b0);
    for (int i = 0; i < 3; i++) push(2'd1, 4'h2, 32'hdead, 1'b0, "R5");
    pop_chk(2'd0, 4'h1, 32'd0, "R2");
    chk("R6", in_ready, 1'b0);
    pop_chk(2'd3, 4'hF, 32'd3, "R6");
    push(2'd3, 4'h6, 32'hbeef, 1'b1, "R6");
    pop_chk(2'd3, 4'h6, 32'hbeef, "R4");
    for (int i = 1; i < 16; i++) pop_chk(2'd0, 4'h1, 32'(i), "R2");
    @(negedge clk);
    chk("R10", {out_valid, in_ready}, 2'b01);

    // R7 saturation
    for (int i = 0; i < 16; i++) push(2'd1, 4'h3, 32'(i), 1'b1, "R3");
    @(negedge clk);
    in_valid = 1'b1;
    repeat (300) @(negedge clk);
    in_valid = 1'b0;
    pop_chk(2'd1, 4'h3, 32'd0, "R2");
    pop_chk(2'd3, 4'hF, 32'd255, "R7");
    drain();

    // R8 R9 watermark with hysteresis
    wm_level = 5'd6; wm_en = 1'b1;
    for (int i = 0; i < 5; i++) push(2'd0, 4'h1, 32'(i), 1'b1, "R8");
    @(negedge clk);
    chk("R8", halt_req, 1'b0);
    push(2'd0, 4'h1, 32'd5, 1'b1, "R8");
    chk("R8", halt_req, 1'b0);
    @(negedge clk);
    chk("R8", halt_req, 1'b1);
    pop_chk(2'd0, 4'h1, 32'd0, "R2");
    pop_chk(2'd0, 4'h1, 32'd1, "R2");
    chk("R9", halt_req, 1'b1);
    pop_chk(2'd0, 4'h1, 32'd2, "R2");
    chk("R9", halt_req, 1'b1);
    @(negedge clk);
    chk("R9", halt_req, 1'b0);
    for (int i = 0; i < 3; i++) push(2'd0, 4'h1, 32'd9, 1'b1, "R8");
    @(negedge clk);
    chk("R8", halt_req, 1'b1);
    wm_en = 1'b0;
    @(negedge clk);
    chk("R9", halt_req, 1'b0);
    drain();

    // R10 simultaneous accept and removal
    push(2'd0, 4'h2, 32'hA, 1'b1, "R10");
    @(negedge clk);
    in_valid = 1'b1; in_prio = 2'd0; in_type = 4'h2; in_payload = 32'hB;
    out_ready = 1'b1;
    chk("R10", out_payload, 32'hA);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    chk("R10", {out_valid, out_payload}, {1'b1, 32'hB});
    for (int i = 0; i < 15; i++) push(2'd0, 4'h2, 32'(i), 1'b1, "R10");
    chk("R3", in_ready, 1'b0);
    drain();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule